// File: doc/BRIEF.md
# Segment Descriptor Translation Unit

This block turns a logical address, made of a 16-bit segment selector and a 32-bit offset, into a linear address. The index field of the selector picks one 64-bit descriptor out of a descriptor table in memory. The table's start address comes from a plain base input. The unit reads the descriptor as two 32-bit words through a single-outstanding memory read port. It checks the descriptor's present and writable bits and its limit against the request. If every check passes, it adds the segment base to the offset.

Requests enter on a valid/ready channel and results leave on a valid/ready channel. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the unit is idle, so one translation is in flight at a time. A result is offered with `rsp_valid` and stays unchanged until the edge where `rsp_ready` is also high, so the consumer can hold it off for any number of cycles. On the memory side, `mem_rd` with `mem_addr` is held until `mem_gnt`. Read data is taken on a later cycle where `mem_rvalid` is high.

Descriptor layout: the word at the descriptor address holds the 32-bit segment base. The word at address +4 holds the limit in bits 19:0, the writable flag in bit 30 and the present flag in bit 31. Fault codes on `rsp_fault` are: 0 none, 1 null selector, 2 segment absent, 3 write protection, 4 limit exceeded.

Top module: `seg_xlate`

## Requirements
- R1: The descriptor index is selector bits 15:3, and selector bits 2:0 have no effect on the result. The first descriptor read goes to `tbl_base + index*8` and the second read goes to that address + 4.
- R2: A selector whose index is 0 yields fault code 1 with no memory read. `rsp_valid` rises at the same edge that accepts that request.
- R3: A descriptor whose present flag (second word, bit 31) is clear yields fault code 2. This check takes priority over R4 and R5.
- R4: A write request (`req_write`=1) to a descriptor whose writable flag (second word, bit 30) is clear yields fault code 3. This check takes priority over R5.
- R5: An offset greater than the 20-bit limit (second word, bits 19:0, zero-extended) yields fault code 4. An offset equal to the limit is allowed.
- R6: When no fault occurs, `rsp_fault` is 0 and `rsp_lin` is the first descriptor word plus the offset, modulo 2^32. Whenever `rsp_fault` is non-zero, `rsp_lin` is 0.
- R7: `req_ready` is high only while no translation is in flight. A request is taken on an edge where `req_valid` and `req_ready` are both high.
- R8: Once `rsp_valid` is high, it stays high with `rsp_lin` and `rsp_fault` unchanged until an edge with `rsp_ready` high. After that edge the unit is idle again.
- R9: A non-null request makes exactly two memory reads. `mem_rd` and `mem_addr` hold steady until `mem_gnt`. `mem_rd` is never high while a result is being offered.
- R10: When `mem_gnt` is high at once and read data returns in the cycle after the grant, `rsp_valid` of a non-null request rises five edges after the accepting edge.
- R11: While reset is asserted, `req_ready` is 1, and `rsp_valid` and `mem_rd` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_base | input | 32 | Byte address of descriptor table |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle, can take a request |
| req_sel | input | 16 | Segment selector |
| req_off | input | 32 | Offset within segment |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | Result offered |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_lin | output | 32 | Linear address (0 on fault) |
| rsp_fault | output | 3 | Fault code |
| mem_rd | output | 1 | Descriptor word read request |
| mem_gnt | input | 1 | Memory accepts the read |
| mem_addr | output | 32 | Descriptor word address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The result of a null selector is visible in the first cycle after the accepting edge. Any other result needs five edges with a zero-wait memory: two grants, two data captures and one check-and-add edge. The bench samples on falling edges and counts them from the accepting edge. It checks that count exactly in the zero-wait pass. In the pass with grant stalls and held-off results, it waits for `rsp_valid` and then for the chosen hold time before it compares the result fields. One falling edge after releasing `rsp_ready`, it expects the unit to be idle.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_NULL   = 3'd1,
    FLT_ABSENT = 3'd2,
    FLT_PROT   = 3'd3,
    FLT_LIMIT  = 3'd4
  } fault_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_LO,
    S_WT_LO,
    S_RD_HI,
    S_WT_HI,
    S_CHECK,
    S_RESP
  } xl_state_e;

endpackage

// File: rtl/seg_desc_decode.sv
module seg_desc_decode #(
  parameter int AW    = 32,
  parameter int LIMW  = 20,
  parameter int P_BIT = AW - 1,
  parameter int W_BIT = AW - 2
) (
  input  logic [AW-1:0]   word_lo,
  input  logic [AW-1:0]   word_hi,
  output logic [AW-1:0]   seg_base,
  output logic [LIMW-1:0] seg_limit,
  output logic            seg_present,
  output logic            seg_writable
);

  // Bits between the limit and the flags carry no meaning.
  logic unused_gap;
  assign unused_gap = ^word_hi[W_BIT-1:LIMW];

  assign seg_base     = word_lo;
  assign seg_limit    = word_hi[LIMW-1:0];
  assign seg_present  = word_hi[P_BIT];
  assign seg_writable = word_hi[W_BIT];

endmodule

// File: rtl/seg_fault_check.sv
module seg_fault_check
  import seg_xlate_pkg::*;
#(
  parameter int AW   = 32,
  parameter int LIMW = 20
) (
  input  logic [AW-1:0]   seg_base,
  input  logic [LIMW-1:0] seg_limit,
  input  logic            seg_present,
  input  logic            seg_writable,
  input  logic [AW-1:0]   offset,
  input  logic            is_write,
  output fault_e          fault,
  output logic [AW-1:0]   lin_addr
);

  always_comb begin
    fault = FLT_NONE;
    if (!seg_present)                fault = FLT_ABSENT;
    else if (is_write && !seg_writable) fault = FLT_PROT;
    else if (offset > AW'(seg_limit))   fault = FLT_LIMIT;
    lin_addr = (fault == FLT_NONE) ? seg_base + offset : '0;
  end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int AW      = 32,
  parameter int SELW    = 16,
  parameter int IDX_LSB = 3,
  parameter int LIMW    = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   tbl_base,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [SELW-1:0] req_sel,
  input  logic [AW-1:0]   req_off,
  input  logic            req_write,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [AW-1:0]   rsp_lin,
  output logic [2:0]      rsp_fault,
  output logic            mem_rd,
  input  logic            mem_gnt,
  output logic [AW-1:0]   mem_addr,
  input  logic            mem_rvalid,
  input  logic [AW-1:0]   mem_rdata
);

  localparam int IDXW       = SELW - IDX_LSB;
  localparam int WORD_BYTES = AW / 8;
  localparam int DESC_SHIFT = $clog2(2 * WORD_BYTES);

  xl_state_e       state;
  logic [AW-1:0]   off_q, addr_q, lo_q, hi_q, lin_q;
  logic            wr_q;
  fault_e          flt_q;
  logic [IDXW-1:0] idx;

  logic [AW-1:0]   d_base, c_lin;
  logic [LIMW-1:0] d_limit;
  logic            d_present, d_writable;
  fault_e          c_fault;

  // Requested privilege bits below the index are not used.
  logic unused_rpl;
  assign unused_rpl = ^req_sel[IDX_LSB-1:0];
  assign idx        = req_sel[SELW-1:IDX_LSB];

  seg_desc_decode #(.AW(AW), .LIMW(LIMW)) u_dec (
    .word_lo      (lo_q),
    .word_hi      (hi_q),
    .seg_base     (d_base),
    .seg_limit    (d_limit),
    .seg_present  (d_present),
    .seg_writable (d_writable)
  );

  seg_fault_check #(.AW(AW), .LIMW(LIMW)) u_chk (
    .seg_base     (d_base),
    .seg_limit    (d_limit),
    .seg_present  (d_present),
    .seg_writable (d_writable),
    .offset       (off_q),
    .is_write     (wr_q),
    .fault        (c_fault),
    .lin_addr     (c_lin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      off_q  <= '0;
      addr_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      lin_q  <= '0;
      wr_q   <= 1'b0;
      flt_q  <= FLT_NONE;
    end else begin
      unique case (state)
        S_IDLE: if (req_valid) begin
          off_q  <= req_off;
          wr_q   <= req_write;
          addr_q <= tbl_base + (AW'(idx) << DESC_SHIFT);
          if (idx == '0) begin
            flt_q <= FLT_NULL;
            lin_q <= '0;
            state <= S_RESP;
          end else begin
            state <= S_RD_LO;
          end
        end
        S_RD_LO: if (mem_gnt) state <= S_WT_LO;
        S_WT_LO: if (mem_rvalid) begin
          lo_q  <= mem_rdata;
          state <= S_RD_HI;
        end
        S_RD_HI: if (mem_gnt) state <= S_WT_HI;
        S_WT_HI: if (mem_rvalid) begin
          hi_q  <= mem_rdata;
          state <= S_CHECK;
        end
        S_CHECK: begin
          flt_q <= c_fault;
          lin_q <= c_lin;
          state <= S_RESP;
        end
        S_RESP: if (rsp_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (state == S_IDLE);
  assign rsp_valid = (state == S_RESP);
  assign rsp_lin   = lin_q;
  assign rsp_fault = flt_q;
  assign mem_rd    = (state == S_RD_LO) || (state == S_RD_HI);
  assign mem_addr  = (state == S_RD_HI) ? addr_q + AW'(WORD_BYTES) : addr_q;

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int AW   = 32,
  parameter int IDXW = 13
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [IDXW-1:0] sel_idx,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [AW-1:0]   rsp_lin,
  input logic [2:0]      rsp_fault,
  input logic            mem_rd,
  input logic            mem_gnt,
  input logic [AW-1:0]   mem_addr
);

  AST_BUSY_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R7

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_lin) && $stable(rsp_fault)); // R8

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && !mem_gnt |=> mem_rd && $stable(mem_addr)); // R9

  AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> !rsp_valid && !req_ready); // R9

  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault != 3'd0 |-> rsp_lin == '0); // R6

  AST_NULL_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && sel_idx == '0 |=> rsp_valid && rsp_fault == 3'd1); // R2

endmodule

bind seg_xlate seg_xlate_chk #(.AW(AW), .IDXW(SELW - IDX_LSB)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .sel_idx   (req_sel[SELW-1:IDX_LSB]),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_lin   (rsp_lin),
  .rsp_fault (rsp_fault),
  .mem_rd    (mem_rd),
  .mem_gnt   (mem_gnt),
  .mem_addr  (mem_addr)
);

// File: tb/sim_seg_xlate.sv
module sim_seg_xlate;

  localparam logic [31:0] TBASE = 32'h0000_4000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tbl_base = TBASE;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_sel = '0;
  logic [31:0] req_off = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_lin;
  logic [2:0]  rsp_fault;
  logic        mem_rd;
  logic        mem_gnt = 1'b1;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #4 clk = ~clk;

  seg_xlate u0 (
    .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_sel(req_sel),
    .req_off(req_off), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_lin(rsp_lin),
    .rsp_fault(rsp_fault),
    .mem_rd(mem_rd), .mem_gnt(mem_gnt), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;
  bit          stall = 1'b0;
  bit          gtog = 1'b0;
  bit          pend = 1'b0;
  logic [31:0] pend_a = '0;
  int          rd_cnt = 0;
  logic [31:0] rd_addr [0:3];

  function automatic logic [31:0] dbase(int i);
    return 32'h1000_0000 + 32'(i) * 32'h0001_1000;
  endfunction
  function automatic logic [19:0] dlim(int i);
    return 20'(i * 16 + 7);
  endfunction
  function automatic bit dpres(int i);
    return (i % 5) != 0;
  endfunction
  function automatic bit dwrit(int i);
    return (i % 3) != 0;
  endfunction
  function automatic logic [31:0] mem_word(logic [31:0] a);
    int i;
    i = int'((a - TBASE) >> 3);
    if (a[2]) return {dpres(i), dwrit(i), 10'h0, dlim(i)};
    return dbase(i);
  endfunction

  // Memory model: grant (optionally every other cycle), data one cycle later.
  initial begin
    forever begin
      @(negedge clk);
      if (pend) begin
        mem_rvalid = 1'b1;
        mem_rdata  = mem_word(pend_a);
        pend       = 1'b0;
      end else begin
        mem_rvalid = 1'b0;
      end
      gtog    = ~gtog;
      mem_gnt = stall ? gtog : 1'b1;
      if (mem_rd && mem_gnt) begin
        pend   = 1'b1;
        pend_a = mem_addr;
        if (rd_cnt < 4) rd_addr[rd_cnt] = mem_addr;
        rd_cnt++;
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_one(int idx, bit wr, logic [31:0] off, int hold);
    logic [15:0] sel;
    logic [2:0]  ef;
    logic [31:0] el;
    string       ftag;
    int          lat;
    sel = {13'(idx), 3'(idx * 5)};
    if (idx == 0)                  begin ef = 3'd1; ftag = "R2 null fault"; end
    else if (!dpres(idx))          begin ef = 3'd2; ftag = "R3 absent fault"; end
    else if (wr && !dwrit(idx))    begin ef = 3'd3; ftag = "R4 protect fault"; end
    else if (off > {12'h0, dlim(idx)}) begin ef = 3'd4; ftag = "R5 limit fault"; end
    else                           begin ef = 3'd0; ftag = "R5 R6 no fault"; end
    el = (ef == 3'd0) ? dbase(idx) + off : 32'h0;

    @(negedge clk);
    rd_cnt    = 0;
    req_sel   = sel;
    req_off   = off;
    req_write = wr;
    req_valid = 1'b1;
    check("R7 ready when idle", 32'(req_ready), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    if (idx != 0) check("R7 ready low in flight", 32'(req_ready), 32'd0);
    while (!rsp_valid && lat < 60) begin
      @(negedge clk);
      lat++;
    end
    if (!stall) check("R10 R2 latency", 32'(lat), (idx == 0) ? 32'd1 : 32'd6);
    repeat (hold) @(negedge clk);
    check("R8 valid held", 32'(rsp_valid), 32'd1);
    check(ftag, 32'(rsp_fault), 32'(ef));
    check("R6 R1 linear address", rsp_lin, el);
    if (idx == 0) begin
      check("R2 no memory read", 32'(rd_cnt), 32'd0);
    end else begin
      check("R9 two reads", 32'(rd_cnt), 32'd2);
      check("R1 low word address", rd_addr[0], TBASE + 32'(idx) * 32'd8);
      check("R1 high word address", rd_addr[1], TBASE + 32'(idx) * 32'd8 + 32'd4);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check("R8 valid drops after take", 32'(rsp_valid), 32'd0);
    check("R7 idle after take", 32'(req_ready), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset req_ready", 32'(req_ready), 32'd1);
    check("R11 reset rsp_valid", 32'(rsp_valid), 32'd0);
    check("R11 reset mem_rd", 32'(mem_rd), 32'd0);
    rst_n = 1'b1;
    for (int pass = 0; pass < 2; pass++) begin
      stall = (pass == 1);
      for (int idx = 0; idx < 16; idx++) begin
        for (int wr = 0; wr < 2; wr++) begin
          for (int k = 0; k < 4; k++) begin
            logic [31:0] off;
            case (k)
              0: off = 32'h0;
              1: off = {12'h0, dlim(idx)};
              2: off = {12'h0, dlim(idx)} + 32'd1;
              default: off = 32'hFFFF_FFFF;
            endcase
            run_one(idx, wr[0], off, pass * ((idx + k) % 3));
          end
        end
      end
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R7 watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule